// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block takes up to four asynchronous interrupt pins from outside the chip. It turns each pin into its own interrupt line toward a parent interrupt controller. Each pin is brought into the clock domain through a two-flop synchroniser. Its trigger condition is chosen by three independent bits: a polarity bit, a both-edges bit and a level-select bit. Five trigger types can be set this way: rising edge, falling edge, either edge, low level and high level. In the edge types a detected transition sets a sticky status bit. In the level types the status bit tracks the active level.

All per-pin settings, the status, the write-1 acknowledge bits and the enable mask sit in one 32-bit word. The word is read combinationally and written whole in a single cycle, so software changes one pin's setting with a read-modify-write. Each control occupies a field whose start is a fixed multiple of a build-time stride (4 or 5). Bit n of every field belongs to pin n.

Top module: `ext_irq_trigger`

## Requirements
- R1: With stride S, the field for pin n sits at bit k*S+n, where k is: polarity 0, status 1, acknowledge 2, enable 3, both-edges 4, level-select 5. With the default S=4 and four pins: polarity [3:0], status [7:4], acknowledge [11:8], enable [15:12], both-edges [19:16], level-select [23:20].
- R2: While reset is held, the word reads with level-select set for every pin and every other bit 0 (0x00F00000 by default), and every irq output is 0. An unconfigured pin is therefore active-low level and masked.
- R3: With level-select 0, both-edges 0 and polarity 0, a low-to-high pin transition sets the pin's status.
- R4: With level-select 0, both-edges 0 and polarity 1, a high-to-low transition sets the status. A rising transition does not set it.
- R5: With level-select 0 and both-edges 1, a transition in either direction sets the status.
- R6: With level-select 1, the status follows the pin: active while the pin is low for polarity 0, and while it is high for polarity 1. An acknowledge has no lasting effect while the level stays active.
- R7: Level-select 1 takes precedence over both-edges 1: the pin behaves as a level input and its status is not sticky.
- R8: In edge modes the status stays set until a 1 is written to the pin's acknowledge bit. After that write cycle it reads 0.
- R9: If an edge is detected in the same cycle as the acknowledge write for that pin, the status remains set.
- R10: Each irq output equals the pin's status AND its enable bit. The status field reads the raw status whatever the enable.
- R11: Written values of the status field, the acknowledge field and bits 31 down to 6*S are ignored. The acknowledge field and those upper bits always read 0.
- R12: A pin change that meets a trigger condition shows at the irq output on the third rising clock edge after the change, counting the two synchroniser stages and the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | NUM_IN | Asynchronous external interrupt pins |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Value written to the control word |
| rd_data_o | output | 32 | Current control word with live status |
| irq_o | output | NUM_IN | Per-pin interrupt lines to the parent controller |

## Verification
A wrong status bit appears at once on the status field of the read word. If the pin is enabled, it also appears on its irq line in the same cycle. A mis-latched configuration bit surfaces on the read word in the cycle after the write. Its effect on detection shows three edges after the next pin transition. The bench compares both outputs with a reference model on every clock. Any divergence is therefore caught within one cycle of the moment it becomes visible at the ports.

// File: rtl/xit_pkg.sv
package xit_pkg;

  // Field indices inside the packed control word; the start of each field is
  // its index times the build-time stride.
  localparam int F_SENSE  = 0;
  localparam int F_STAT   = 1;
  localparam int F_ACK    = 2;
  localparam int F_EN     = 3;
  localparam int F_BOTH   = 4;
  localparam int F_LVL    = 5;
  localparam int N_FIELDS = 6;
  localparam int WORD_W   = 32;

  typedef enum logic [2:0] {
    TRIG_RISE,
    TRIG_FALL,
    TRIG_BOTH,
    TRIG_LOW,
    TRIG_HIGH
  } trig_e;

  // Level-select wins over both-edges; polarity picks the direction.
  function automatic trig_e trig_decode(input logic sense, input logic both,
                                        input logic lvl);
    trig_e t;
    if (lvl)       t = sense ? TRIG_HIGH : TRIG_LOW;
    else if (both) t = TRIG_BOTH;
    else           t = sense ? TRIG_FALL : TRIG_RISE;
    return t;
  endfunction

endpackage

// File: rtl/xit_sync.sv
module xit_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int k = 1; k < STAGES; k++) stage_d[k] = stage_q[k-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= stage_d[k];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/xit_cfg.sv
module xit_cfg
  import xit_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int STRIDE = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic [NUM_IN-1:0]   stat_i,
  output logic [NUM_IN-1:0]   sense_o,
  output logic [NUM_IN-1:0]   both_o,
  output logic [NUM_IN-1:0]   lvl_o,
  output logic [NUM_IN-1:0]   en_o,
  output logic [NUM_IN-1:0]   ack_o,
  output logic [WORD_W-1:0]   rd_data_o
);

  localparam int LSB_SENSE = F_SENSE * STRIDE;
  localparam int LSB_STAT  = F_STAT  * STRIDE;
  localparam int LSB_ACK   = F_ACK   * STRIDE;
  localparam int LSB_EN    = F_EN    * STRIDE;
  localparam int LSB_BOTH  = F_BOTH  * STRIDE;
  localparam int LSB_LVL   = F_LVL   * STRIDE;

  logic [NUM_IN-1:0] sense_q, both_q, lvl_q, en_q;
  logic [NUM_IN-1:0] sense_d, both_d, lvl_d, en_d;
  logic              wr_unused;

  assign wr_unused = ^wr_data_i;

  always_comb begin
    sense_d = sense_q;
    both_d  = both_q;
    lvl_d   = lvl_q;
    en_d    = en_q;
    if (wr_en_i) begin
      sense_d = wr_data_i[LSB_SENSE +: NUM_IN];
      both_d  = wr_data_i[LSB_BOTH  +: NUM_IN];
      lvl_d   = wr_data_i[LSB_LVL   +: NUM_IN];
      en_d    = wr_data_i[LSB_EN    +: NUM_IN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      both_q  <= '0;
      lvl_q   <= '1;
      en_q    <= '0;
    end else if (wr_en_i) begin
      sense_q <= sense_d;
      both_q  <= both_d;
      lvl_q   <= lvl_d;
      en_q    <= en_d;
    end
  end

  // Acknowledge is a one-cycle pulse decoded from the write; nothing stored.
  assign ack_o = wr_en_i ? wr_data_i[LSB_ACK +: NUM_IN] : '0;

  always_comb begin
    rd_data_o = '0;
    rd_data_o[LSB_SENSE +: NUM_IN] = sense_q;
    rd_data_o[LSB_STAT  +: NUM_IN] = stat_i;
    rd_data_o[LSB_EN    +: NUM_IN] = en_q;
    rd_data_o[LSB_BOTH  +: NUM_IN] = both_q;
    rd_data_o[LSB_LVL   +: NUM_IN] = lvl_q;
  end

  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign lvl_o   = lvl_q;
  assign en_o    = en_q;

  // R11
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(sense_q) && $stable(both_q) && $stable(lvl_q) && $stable(en_q)));

endmodule

// File: rtl/xit_chan.sv
module xit_chan
  import xit_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  input  logic sense_i,
  input  logic both_i,
  input  logic lvl_i,
  input  logic ack_i,
  output logic stat_o
);

  logic  prev_q;
  logic  stat_q, stat_d;
  logic  rise, fall, edge_hit;
  trig_e mode;

  assign rise = s_i & ~prev_q;
  assign fall = ~s_i & prev_q;
  assign mode = trig_decode(sense_i, both_i, lvl_i);

  always_comb begin
    edge_hit = 1'b0;
    stat_d   = stat_q;
    unique case (mode)
      TRIG_RISE: edge_hit = rise;
      TRIG_FALL: edge_hit = fall;
      TRIG_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
    unique case (mode)
      TRIG_LOW:  stat_d = ~s_i;
      TRIG_HIGH: stat_d = s_i;
      default:   stat_d = edge_hit | (stat_q & ~ack_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= s_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

  // R8
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i && stat_q && !ack_i) |=> stat_q);

  // R9
  edge_over_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i && edge_hit && ack_i) |=> stat_q);

  // R3
  edge_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stat_q) && !$past(lvl_i)) |-> ($past(s_i) != $past(prev_q)));

endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger
  import xit_pkg::*;
#(
  parameter int NUM_IN      = 4,
  parameter int STRIDE      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] pin_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  output logic [NUM_IN-1:0] irq_o
);

  localparam int LSB_EN  = F_EN  * STRIDE;
  localparam int LSB_ACK = F_ACK * STRIDE;

  logic              rst_sync_n;
  logic [NUM_IN-1:0] pin_s;
  logic [NUM_IN-1:0] sense, both, lvl, en, ack, stat;

  // Reset asserts asynchronously and is released on a clock edge.
  xit_sync #(.WIDTH(1), .STAGES(2)) u_rst_sync (
    .clk_i (clk),
    .rst_ni(rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  xit_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i (clk),
    .rst_ni(rst_sync_n),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  xit_cfg #(.NUM_IN(NUM_IN), .STRIDE(STRIDE)) u_cfg (
    .clk_i    (clk),
    .rst_ni   (rst_sync_n),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .stat_i   (stat),
    .sense_o  (sense),
    .both_o   (both),
    .lvl_o    (lvl),
    .en_o     (en),
    .ack_o    (ack),
    .rd_data_o(rd_data_o)
  );

  for (genvar n = 0; n < NUM_IN; n++) begin : g_chan
    xit_chan u_chan (
      .clk_i  (clk),
      .rst_ni (rst_sync_n),
      .s_i    (pin_s[n]),
      .sense_i(sense[n]),
      .both_i (both[n]),
      .lvl_i  (lvl[n]),
      .ack_i  (ack[n]),
      .stat_o (stat[n])
    );
  end

  assign irq_o = stat & en;

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_o & ~rd_data_o[LSB_EN +: NUM_IN]) == '0);

  // R11
  ack_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data_o[LSB_ACK +: NUM_IN] == '0);

endmodule

// File: tb/ext_irq_trigger_bench.sv
`timescale 1ns/1ps
module ext_irq_trigger_bench;

  localparam logic [31:0] CFG = 32'h0084F00A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin = 4'b1111;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  ext_irq_trigger u_ext_irq_trigger (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .irq_o(irq)
  );

  // Behavioural reference: pin delay line, configuration, status.
  logic [3:0] m_q1, m_q2, m_prev, m_sense, m_both, m_lvl, m_en, m_st;
  int         live_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q1 = 0; m_q2 = 0; m_prev = 0; m_sense = 0; m_both = 0;
      m_lvl = 4'hF; m_en = 0; m_st = 0; live_cnt = 0;
    end else if (live_cnt < 2) begin
      live_cnt++;
    end else begin
      logic [3:0] nst;
      for (int i = 0; i < 4; i++) begin
        logic s, p, ack, hit;
        s = m_q2[i]; p = m_prev[i];
        ack = wr_en && wr_data[8+i];
        if (m_lvl[i]) nst[i] = m_sense[i] ? s : !s;
        else begin
          if (m_both[i])       hit = (s != p);
          else if (m_sense[i]) hit = p && !s;
          else                 hit = s && !p;
          nst[i] = hit || (m_st[i] && !ack);
        end
      end
      m_st = nst;
      if (wr_en) begin
        m_sense = wr_data[3:0]; m_en = wr_data[15:12];
        m_both = wr_data[19:16]; m_lvl = wr_data[23:20];
      end
      m_prev = m_q2; m_q2 = m_q1; m_q1 = pin;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R1 R10: every-clock comparison against the reference model.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rd_data, {8'h00, m_lvl, m_both, m_en, 4'h0, m_st, m_sense}, "R1 word vs model");
      chk({28'h0, irq}, {28'h0, m_st & m_en}, "R10 irq vs model");
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog timeout");
      summary();
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    step(3);
    chk(rd_data, 32'h00F00000, "R2 reset word");
    chk({28'h0, irq}, 32'h0, "R2 reset irq");
    rst_n = 1'b1;
    step(6);

    wr(CFG); step(1);
    chk(rd_data & 32'hFFFFFF0F, CFG, "R1 config readback");
    chk({28'h0, irq}, 32'h8, "R6 high level active");

    pin = 4'b1110; step(5);
    pin = 4'b1111; step(2);
    chk({31'h0, irq[0]}, 32'h0, "R12 not before third edge");
    step(1);
    chk({31'h0, irq[0]}, 32'h1, "R3 R12 rising at third edge");

    step(8);
    chk({31'h0, irq[0]}, 32'h1, "R8 sticky");
    wr(CFG | 32'h100);
    chk({28'h0, rd_data[7:4]}, 32'h8, "R8 acknowledge clears");

    wr(CFG | 32'hF0);
    chk({28'h0, rd_data[7:4]}, 32'h8, "R11 status write ignored");

    pin = 4'b1101; step(3);
    chk({31'h0, irq[1]}, 32'h1, "R4 falling");
    wr(CFG | 32'h200);
    pin = 4'b1111; step(4);
    chk({31'h0, irq[1]}, 32'h0, "R4 rising ignored");

    pin = 4'b1011; step(3);
    chk({31'h0, irq[2]}, 32'h1, "R5 both falling");
    wr(CFG | 32'h400);
    chk({31'h0, irq[2]}, 32'h0, "R5 cleared");
    pin = 4'b1111; step(3);
    chk({31'h0, irq[2]}, 32'h1, "R5 both rising");
    wr(CFG | 32'h400);

    wr(CFG | 32'h800); step(1);
    chk({31'h0, rd_data[7]}, 32'h1, "R6 ack no effect on level");
    pin = 4'b0111; step(3);
    chk({31'h0, irq[3]}, 32'h0, "R6 level dropped");
    pin = 4'b1111; step(3);

    wr(32'h0084700A);
    chk({31'h0, irq[3]}, 32'h0, "R10 masked");
    chk({31'h0, rd_data[7]}, 32'h1, "R10 raw status");
    wr(CFG);
    chk({31'h0, irq[3]}, 32'h1, "R10 unmasked");

    pin = 4'b1110; step(5);
    pin = 4'b1111; step(3);
    pin = 4'b1110; step(5);
    pin = 4'b1111; step(2);
    wr(CFG | 32'h100);
    chk({31'h0, irq[0]}, 32'h1, "R9 edge beats ack");
    wr(CFG | 32'h100);
    chk({31'h0, irq[0]}, 32'h0, "R9 later ack clears");

    wr(32'h00C4F00A); step(2);
    pin = 4'b1011; step(3);
    chk({31'h0, irq[2]}, 32'h1, "R7 level wins active");
    pin = 4'b1111; step(3);
    chk({31'h0, irq[2]}, 32'h0, "R7 not sticky");

    wr(32'hFFFFFFFF);
    chk(rd_data & 32'hFF000F00, 32'h0, "R11 upper and ack read zero");
    chk({20'h0, rd_data[23:12]}, 32'hFFF, "R11 config fields");
    chk({28'h0, rd_data[3:0]}, 32'hF, "R11 polarity field");
    step(4);

    summary();
    $finish;
  end

endmodule